// File: doc/BRIEF.md
# Synchronous Serial Port with Error Detection

This block is a synchronous serial port that runs as either the clock master or a clock slave. It is programmed through a small word-addressed register bus. In master mode, writing the transmit buffer starts a transfer. A reloadable down-counter sets the half-period of the shift clock, and the port drives that clock out. In slave mode, the first rising edge of an external shift clock starts a transfer, and the port shifts on that clock. Words are exchanged most significant bit first. Outgoing data changes on the falling edge of the shift clock, and incoming data is sampled on the rising edge.

Four sticky error flags report conditions that software must handle:

- A slave transfer started before new transmit data was written.
- A new word arrived before the previous one was read.
- The receive line moved near a sampling edge.
- The slave clock ran far off the programmed rate.

Software clears each flag by writing a one to the matching bit of a write-only clear register. A three-bit selector picks pin A or pin B for each of three inputs. All three inputs are synchronised through two flops before use.

The transfer engine is a state machine with three states:

- `ST_IDLE`: waiting for a transfer.
- `ST_MSHIFT`: master transfer in progress.
- `ST_SSHIFT`: slave transfer in progress.

Its transitions are:

- **master-start**: `ST_IDLE`→`ST_MSHIFT` on a transmit-buffer write while enabled in master mode.
- **slave-start**: `ST_IDLE`→`ST_SSHIFT` on a synchronised clock rise while enabled in slave mode.
- **word-end**: `ST_MSHIFT`/`ST_SSHIFT`→`ST_IDLE` on the falling edge that follows the last sample.
- **abort**: `ST_MSHIFT`/`ST_SSHIFT`→`ST_IDLE` when the enable bit is cleared or the mode bit changes mid-word.

Top module: `ssc_port`

## Requirements
- R1: After reset every register reads zero. Byte offsets are: 0x00 pin select, 0x04 control, 0x08 transmit buffer, 0x0C receive buffer (read-only), 0x10 baud reload (15 bits). Data words are 8 bits in [7:0].
- R2: Control bit 15 is the enable bit and bit 14 selects master mode (1) or slave mode (0); both are writable. In master mode `ser_clk_oe` is 1, the shift clock idles low, and each clock period lasts 2*(reload+1) system clocks.
- R3: A master transfer shifts `ser_dout` out MSB first, changing on the falling edge. It samples the receive line on each rising edge. After 8 bits the received word is placed in the receive buffer. Control bit 12 (busy) is 1 for the duration of the transfer.
- R4: Pin-select bit 0 chooses `mrx_b` over `mrx_a` for master receive data. Bit 1 makes the same choice for slave receive data, and bit 2 for the slave clock.
- R5: In slave mode the first rising edge of the selected clock starts a transfer. The port then exchanges 8 bits on that clock, sending the transmit buffer contents.
- R6: Control bit 8 (transmit error) sets when a slave transfer starts and the transmit buffer has not been written since the previous slave transfer started.
- R7: Control bit 9 (receive error) sets when a transfer completes while the previous received word has not been read. The receive buffer still takes the newer word.
- R8: In slave mode, control bit 10 (phase error) sets when the synchronised receive line two clocks after a sampling edge differs from its value two clocks before that edge.
- R9: In slave mode, control bit 11 (baud error) sets when the measured rise-to-rise period m satisfies 2m < P or m > 2P, where P = 2*(reload+1). A period of exactly 2P is not an error.
- R10: Writing 1 to bit 8, 9, 10 or 11 of the clear register (offset 0x14) clears the error flag at the same bit position in the control register. Writing 0 has no effect. A flag that sets in the same cycle as its clear stays set.
- R11: While the enable bit is 0, no transfer starts and clock edges on the pins are ignored. Clearing the enable bit during a transfer returns the port to idle with the shift clock low.
- R12: Control bits [2:0] give the number of bits sampled so far in the current word, modulo 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| ser_clk_o | output | 1 | Shift clock driven in master mode |
| ser_clk_oe | output | 1 | Output enable for the shift clock |
| ser_dout | output | 1 | Serial transmit data |
| mrx_a | input | 1 | Master receive data, pin A |
| mrx_b | input | 1 | Master receive data, pin B |
| srx_a | input | 1 | Slave receive data, pin A |
| srx_b | input | 1 | Slave receive data, pin B |
| sck_a | input | 1 | Slave clock, pin A |
| sck_b | input | 1 | Slave clock, pin B |

## Verification
The embedded assertions check properties on every cycle:

- The shift clock is low whenever the port is idle.
- A cleared enable forces idle on the next cycle.
- The sampled-bit count never passes the word length.
- The baud counter reloads while stopped.
- Error flags are sticky unless cleared.
- The receive and transmit errors rise only after a completed transfer or a slave start.

Other behaviours can only be shown by the bench's scenarios:

- The data values exchanged and the shift-clock period.
- Pin selection.
- The phase-error response to a data edge aligned with the clock.
- The baud-error boundaries for slow, fast and exactly-2P clocks.
- That a disabled port ignores a whole slave word.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    localparam int AW = 5;
    localparam int RW = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MSHIFT = 2'd1,
        ST_SSHIFT = 2'd2
    } xfer_state_t;

    localparam logic [AW-1:0] ADR_PSEL = 5'h00;
    localparam logic [AW-1:0] ADR_CTRL = 5'h04;
    localparam logic [AW-1:0] ADR_TXB  = 5'h08;
    localparam logic [AW-1:0] ADR_RXB  = 5'h0C;
    localparam logic [AW-1:0] ADR_RLD  = 5'h10;
    localparam logic [AW-1:0] ADR_CLR  = 5'h14;

    localparam int ERR_LSB  = 8;
    localparam int BUSY_BIT = 12;
    localparam int MS_BIT   = 14;
    localparam int EN_BIT   = 15;

    localparam int ERR_TE = 0;
    localparam int ERR_RE = 1;
    localparam int ERR_PE = 2;
    localparam int ERR_BE = 3;
endpackage

// File: rtl/ssc_baud_gen.sv
module ssc_baud_gen #(
    parameter int BW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [BW-1:0] reload,
    output logic          tick
);
    logic [BW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run)         cnt <= reload;
        else if (cnt == '0)    cnt <= reload;
        else                   cnt <= cnt - 1'b1;
    end

    assign tick = run && (cnt == '0);

    // R2: a stopped timer is primed so the first half-period is full length
    assert_hold_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == $past(reload)));
endmodule

// File: rtl/ssc_in_sel.sv
module ssc_in_sel #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_a,
    input  logic [N-1:0] pin_b,
    input  logic [N-1:0] sel,
    output logic [N-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= sel[g] ? pin_b[g] : pin_a[g];
                s2 <= s1;
            end
        end
        assign q[g] = s2;
    end
endmodule

// File: rtl/ssc_shift_fsm.sv
module ssc_shift_fsm
    import ssc_pkg::*;
#(
    parameter int DW = 8,
    parameter int BW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          master,
    input  logic          tx_load,
    input  logic [DW-1:0] tx_data,
    input  logic [DW-1:0] tx_hold,
    input  logic          tick,
    input  logic          sclk_in,
    input  logic          rxd_in,
    input  logic [BW-1:0] reload,
    output logic          busy,
    output logic          run,
    output logic          ser_clk,
    output logic          dout,
    output logic [2:0]    bit_cnt,
    output logic          xfer_done,
    output logic [DW-1:0] rx_word,
    output logic          s_start,
    output logic          ev_pe,
    output logic          ev_be
);
    localparam int CB = $clog2(DW + 1);
    localparam logic [CB-1:0] LAST = CB'(DW);
    localparam int CW = BW + 3;
    localparam int PW = BW + 5;

    xfer_state_t state, state_nx;
    logic          sclk_q, smp, sclk_prev, s_rise, s_fall, m_rise, m_fall;
    logic          rise_ev, fall_ev, last_fall, aborting, d1, d2, pref;
    logic [DW-1:0] sh;
    logic [CB-1:0] nbits;
    logic [CW-1:0] per_cnt;
    logic [PW-1:0] meas, nominal;
    logic [1:0]    pc;

    assign s_rise  = sclk_in & ~sclk_prev;
    assign s_fall  = ~sclk_in & sclk_prev;
    assign m_rise  = tick & ~sclk_q;
    assign m_fall  = tick & sclk_q;
    assign s_start = (state == ST_IDLE) && en && !master && s_rise;

    always_comb begin
        rise_ev = 1'b0;
        fall_ev = 1'b0;
        unique case (state)
            ST_MSHIFT: begin rise_ev = m_rise; fall_ev = m_fall; end
            ST_SSHIFT: begin rise_ev = s_rise; fall_ev = s_fall; end
            default:   ;
        endcase
    end

    assign aborting  = ((state == ST_MSHIFT) && (!en || !master)) ||
                       ((state == ST_SSHIFT) && (!en || master));
    assign last_fall = fall_ev && (nbits == LAST) && !aborting;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: master-start, slave-start, word-end, abort
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (en && master && tx_load) state_nx = ST_MSHIFT;
                else if (s_start)            state_nx = ST_SSHIFT;
            end
            ST_MSHIFT, ST_SSHIFT: begin
                if (aborting || last_fall)   state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath and monitors
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0; smp <= 1'b0; sclk_prev <= 1'b0;
            sh <= '0; nbits <= '0; per_cnt <= '0;
            d1 <= 1'b0; d2 <= 1'b0; pref <= 1'b0; pc <= 2'd0;
        end else begin
            sclk_prev <= sclk_in;
            d1 <= rxd_in;
            d2 <= d1;
            if (state == ST_IDLE) begin
                sh      <= tx_load ? tx_data : tx_hold;
                sclk_q  <= 1'b0;
                per_cnt <= '0;
                nbits   <= s_start ? CB'(1) : '0;
                if (s_start) smp <= rxd_in;
            end else if (aborting) begin
                sclk_q  <= 1'b0;
                nbits   <= '0;
                per_cnt <= '0;
            end else begin
                if ((state == ST_MSHIFT) && tick) sclk_q <= ~sclk_q;
                if (rise_ev) begin
                    smp   <= rxd_in;
                    nbits <= nbits + 1'b1;
                end
                if (fall_ev) begin
                    sh <= {sh[DW-2:0], smp};
                    if (last_fall) nbits <= '0;
                end
                if (s_rise)              per_cnt <= '0;
                else if (per_cnt != '1)  per_cnt <= per_cnt + 1'b1;
            end
            if (s_start || ((state == ST_SSHIFT) && s_rise && !aborting)) begin
                pref <= d2;
                pc   <= 2'd2;
            end else if (pc != 2'd0) begin
                pc <= pc - 1'b1;
            end
        end
    end

    assign meas    = PW'(per_cnt) + 1'b1;
    assign nominal = (PW'(reload) + 1'b1) << 1;
    assign ev_be   = (state == ST_SSHIFT) && s_rise && !aborting &&
                     (((meas << 1) < nominal) || (meas > (nominal << 1)));
    assign ev_pe   = (pc == 2'd1) && (rxd_in != pref);

    assign busy      = (state != ST_IDLE);
    assign run       = (state == ST_MSHIFT);
    assign ser_clk   = sclk_q;
    assign dout      = sh[DW-1];
    assign bit_cnt   = nbits[2:0];
    assign xfer_done = last_fall;
    assign rx_word   = {sh[DW-2:0], smp};

    assert_idle_clk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_clk);
    assert_disable_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
    assert_bits_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nbits <= LAST);
endmodule

// File: rtl/ssc_port.sv
module ssc_port
    import ssc_pkg::*;
#(
    parameter int DW = 8,
    parameter int BW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [RW-1:0] bus_wdata,
    output logic [RW-1:0] bus_rdata,
    output logic          ser_clk_o,
    output logic          ser_clk_oe,
    output logic          ser_dout,
    input  logic          mrx_a,
    input  logic          mrx_b,
    input  logic          srx_a,
    input  logic          srx_b,
    input  logic          sck_a,
    input  logic          sck_b
);
    logic [2:0]    psel;
    logic          ctl_en, ctl_ms, tx_fresh, rx_unread;
    logic [DW-1:0] txbuf, rxbuf, rx_word;
    logic [BW-1:0] reload;
    logic [3:0]    err, err_set, clr_mask;
    logic          wr, rd, tx_wr, clr_wr;
    logic [2:0]    syn;
    logic          mrx_s, srx_s, sck_s, rxd;
    logic          tick, run, busy, xfer_done, s_start, ev_pe, ev_be;
    logic [2:0]    bit_cnt;
    logic          unused_bits;

    assign wr     = bus_sel && bus_wr;
    assign rd     = bus_sel && !bus_wr;
    assign tx_wr  = wr && (bus_addr == ADR_TXB);
    assign clr_wr = wr && (bus_addr == ADR_CLR);
    assign clr_mask = clr_wr ? bus_wdata[ERR_LSB +: 4] : 4'b0;
    assign unused_bits = ^{bus_wdata[RW-1:DW], bus_wdata[13:12]};

    ssc_in_sel #(.N(3)) u_sel (
        .clk(clk), .rst_n(rst_n),
        .pin_a({sck_a, srx_a, mrx_a}),
        .pin_b({sck_b, srx_b, mrx_b}),
        .sel(psel), .q(syn)
    );
    assign {sck_s, srx_s, mrx_s} = syn;
    assign rxd = ctl_ms ? mrx_s : srx_s;

    ssc_baud_gen #(.BW(BW)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run), .reload(reload), .tick(tick)
    );

    ssc_shift_fsm #(.DW(DW), .BW(BW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(ctl_en), .master(ctl_ms),
        .tx_load(tx_wr), .tx_data(bus_wdata[DW-1:0]), .tx_hold(txbuf),
        .tick(tick), .sclk_in(sck_s), .rxd_in(rxd), .reload(reload),
        .busy(busy), .run(run), .ser_clk(ser_clk_o), .dout(ser_dout),
        .bit_cnt(bit_cnt), .xfer_done(xfer_done), .rx_word(rx_word),
        .s_start(s_start), .ev_pe(ev_pe), .ev_be(ev_be)
    );

    always_comb begin
        err_set = '0;
        err_set[ERR_TE] = s_start && !tx_fresh;
        err_set[ERR_RE] = xfer_done && rx_unread;
        err_set[ERR_PE] = ev_pe;
        err_set[ERR_BE] = ev_be;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psel <= '0; ctl_en <= 1'b0; ctl_ms <= 1'b0;
            txbuf <= '0; rxbuf <= '0; reload <= '0; err <= '0;
            tx_fresh <= 1'b0; rx_unread <= 1'b0;
        end else begin
            if (wr && (bus_addr == ADR_PSEL)) psel <= bus_wdata[2:0];
            if (wr && (bus_addr == ADR_CTRL)) begin
                ctl_en <= bus_wdata[EN_BIT];
                ctl_ms <= bus_wdata[MS_BIT];
            end
            if (wr && (bus_addr == ADR_RLD)) reload <= bus_wdata[BW-1:0];
            if (tx_wr) txbuf <= bus_wdata[DW-1:0];
            if (tx_wr)        tx_fresh <= 1'b1;
            else if (s_start) tx_fresh <= 1'b0;
            if (xfer_done) begin
                rxbuf     <= rx_word;
                rx_unread <= 1'b1;
            end else if (rd && (bus_addr == ADR_RXB)) begin
                rx_unread <= 1'b0;
            end
            err <= (err & ~clr_mask) | err_set;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_PSEL: bus_rdata[2:0] = psel;
            ADR_CTRL: begin
                bus_rdata[2:0]          = bit_cnt;
                bus_rdata[ERR_LSB +: 4] = err;
                bus_rdata[BUSY_BIT]     = busy;
                bus_rdata[MS_BIT]       = ctl_ms;
                bus_rdata[EN_BIT]       = ctl_en;
            end
            ADR_TXB:  bus_rdata[DW-1:0] = txbuf;
            ADR_RXB:  bus_rdata[DW-1:0] = rxbuf;
            ADR_RLD:  bus_rdata[BW-1:0] = reload;
            default:  bus_rdata = '0;
        endcase
    end

    assign ser_clk_oe = ctl_en && ctl_ms;

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err & $past(err & ~clr_mask)) == $past(err & ~clr_mask)));
    assert_re_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err[ERR_RE]) |-> $past(xfer_done));
    assert_te_slave_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err[ERR_TE]) |-> $past(s_start));
endmodule

// File: tb/tb_ssc_port.sv
module tb_ssc_port;
    import ssc_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, bus_sel, bus_wr;
    logic [4:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic ser_clk_o, ser_clk_oe, ser_dout;
    logic mrx_a, mrx_b, srx_a, srx_b, sck_a, sck_b;

    ssc_port dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_clk_o(ser_clk_o), .ser_clk_oe(ser_clk_oe), .ser_dout(ser_dout),
        .mrx_a(mrx_a), .mrx_b(mrx_b), .srx_a(srx_a), .srx_b(srx_b),
        .sck_a(sck_a), .sck_b(sck_b)
    );

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] c;
        for (int n = 0; n < 400; n++) begin
            bus_read(ADR_CTRL, c);
            if (!c[BUSY_BIT]) break;
        end
    endtask

    // scoreboard monitor: pops the expected word and compares with the receive buffer
    task automatic check_rx(input string req);
        logic [15:0] d;
        logic [7:0] e;
        bus_read(ADR_RXB, d);
        if (exp_q.size() == 0) begin
            check({req, " queue empty"}, 1, 0);
        end else begin
            e = exp_q.pop_front();
            check(req, d, {8'h00, e});
        end
    endtask

    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sw, input bit use_b,
                               input bit chk_cnt, input bit push);
        logic [7:0] got;
        logic [15:0] c;
        time t0;
        got = '0;
        t0 = 0;
        @(negedge clk);
        if (use_b) begin mrx_b = sw[7]; mrx_a = ~sw[7]; end
        else       begin mrx_a = sw[7]; mrx_b = ~sw[7]; end
        if (push) exp_q.push_back(sw);
        bus_write(ADR_TXB, {8'h00, tx});
        for (int i = 0; i < 8; i++) begin
            @(posedge ser_clk_o);
            if (i == 1) check("R2 master clock period", 32'($time - t0), 32'd160);
            t0 = $time;
            @(negedge clk);
            got = {got[6:0], ser_dout};
            if (chk_cnt && i == 2) begin
                bus_read(ADR_CTRL, c);
                check("R12 bit count mid-word", c[2:0], 3'd3);
                check("R3 busy mid-word", c[BUSY_BIT], 1'b1);
            end
            if (i < 7) begin
                @(negedge ser_clk_o);
                @(negedge clk);
                if (use_b) begin mrx_b = sw[6-i]; mrx_a = ~sw[6-i]; end
                else       begin mrx_a = sw[6-i]; mrx_b = ~sw[6-i]; end
            end
        end
        wait_idle();
        check("R3 master transmitted word", got, tx);
    endtask

    task automatic slave_xfer(input logic [7:0] sw, input int half, input bit glitch,
                              input bit push, output logic [7:0] got);
        got = '0;
        @(negedge clk);
        srx_a = sw[7]; sck_b = 1'b0; sck_a = 1'b0;
        if (push) exp_q.push_back(sw);
        for (int i = 0; i < 8; i++) begin
            repeat (half) @(negedge clk);
            sck_b = 1'b1;
            got = {got[6:0], ser_dout};
            if (glitch) srx_a = ~srx_a;
            repeat (half) @(negedge clk);
            sck_b = 1'b0;
            if (i < 7) srx_a = sw[6-i];
        end
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d, keep;
        logic [7:0] g;
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        mrx_a = 1'b0; mrx_b = 1'b0; srx_a = 1'b0; srx_b = 1'b0; sck_a = 1'b0; sck_b = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(ADR_CTRL, d); check("R1 control reset", d, 16'h0000);
        bus_read(ADR_RXB, d);  check("R1 rx buffer reset", d, 16'h0000);
        bus_read(ADR_RLD, d);  check("R1 reload reset", d, 16'h0000);
        bus_read(ADR_PSEL, d); check("R1 pin select reset", d, 16'h0000);
        bus_write(ADR_RLD, 16'h0003);
        bus_read(ADR_RLD, d);  check("R1 reload readback", d, 16'h0003);

        // R2 master mode
        bus_write(ADR_CTRL, 16'hC000);
        @(negedge clk);
        check("R2 clock output enable", ser_clk_oe, 1'b1);
        check("R2 clock idles low", ser_clk_o, 1'b0);

        // R3 master exchange, pin A
        master_xfer(8'hA5, 8'h3C, 1'b0, 1'b1, 1'b1);
        check_rx("R3 master received word");
        bus_read(ADR_CTRL, d); check("R3 no errors, idle", d[12:8], 5'h00);

        // R4 master receive on pin B
        bus_write(ADR_PSEL, 16'h0001);
        master_xfer(8'h5A, 8'hC3, 1'b1, 1'b0, 1'b1);
        check_rx("R4 master pin B word");

        // R7 overrun
        master_xfer(8'h0F, 8'h81, 1'b1, 1'b0, 1'b0);
        master_xfer(8'h11, 8'h22, 1'b1, 1'b0, 1'b0);
        bus_read(ADR_CTRL, d); check("R7 receive error set", d[9], 1'b1);
        bus_read(ADR_RXB, d);  check("R7 newest word kept", d, 16'h0022);
        bus_write(ADR_CLR, 16'h0000);
        bus_read(ADR_CTRL, d); check("R10 zero write keeps flag", d[9], 1'b1);
        bus_write(ADR_CLR, 16'h0200);
        bus_read(ADR_CTRL, d); check("R10 one write clears flag", d[11:8], 4'h0);

        // R5 slave, clock on pin B, data on pin A
        bus_write(ADR_CTRL, 16'h8000);
        bus_write(ADR_PSEL, 16'h0004);
        @(negedge clk);
        check("R2 no clock drive in slave", ser_clk_oe, 1'b0);
        bus_write(ADR_TXB, 16'h0096);
        slave_xfer(8'h4B, 4, 1'b0, 1'b1, g);
        check("R5 slave transmitted word", g, 8'h96);
        check_rx("R5 slave received word");
        bus_read(ADR_CTRL, d); check("R6 fresh buffer gives no errors", d[11:8], 4'h0);

        // R6 stale transmit buffer
        slave_xfer(8'h12, 4, 1'b0, 1'b1, g);
        bus_read(ADR_CTRL, d); check("R6 transmit error set", d[8], 1'b1);
        check("R6 stale word resent", g, 8'h96);
        check_rx("R5 second slave word");
        bus_write(ADR_CLR, 16'h0100);

        // R9 boundary: period exactly 2P is not an error
        bus_write(ADR_TXB, 16'h0001);
        slave_xfer(8'h0F, 8, 1'b0, 1'b1, g);
        bus_read(ADR_CTRL, d); check("R9 period 2P no baud error", d[11], 1'b0);
        check_rx("R9 boundary word");

        // R9 slow clock
        bus_write(ADR_TXB, 16'h0002);
        slave_xfer(8'hFF, 12, 1'b0, 1'b1, g);
        bus_read(ADR_CTRL, d); check("R9 slow clock baud error", d[11], 1'b1);
        check_rx("R9 slow word");
        bus_write(ADR_CLR, 16'h0800);
        bus_read(ADR_CTRL, d); check("R10 baud flag cleared", d[11:8], 4'h0);

        // R9 fast clock
        bus_write(ADR_TXB, 16'h0003);
        @(negedge clk); srx_a = 1'b0;
        repeat (6) @(negedge clk);
        slave_xfer(8'h00, 1, 1'b0, 1'b0, g);
        bus_read(ADR_CTRL, d); check("R9 fast clock baud error", d[11], 1'b1);
        bus_read(ADR_RXB, d);
        bus_write(ADR_CLR, 16'h0F00);

        // R8 data edge aligned with sampling edge
        bus_write(ADR_TXB, 16'h0004);
        slave_xfer(8'h55, 4, 1'b1, 1'b0, g);
        bus_read(ADR_CTRL, d); check("R8 phase error set", d[10], 1'b1);
        bus_read(ADR_RXB, d);
        bus_write(ADR_CLR, 16'h0F00);
        bus_read(ADR_CTRL, d); check("R10 all flags cleared", d[11:8], 4'h0);

        // R11 disabled port ignores a whole word
        bus_write(ADR_CTRL, 16'h0000);
        bus_read(ADR_RXB, keep);
        slave_xfer(8'hE7, 4, 1'b0, 1'b0, g);
        bus_read(ADR_RXB, d);  check("R11 disabled rx buffer unchanged", d, keep);
        bus_read(ADR_CTRL, d); check("R11 disabled stays idle, no flags", d[12:8], 5'h00);

        // R11 abort mid-word
        bus_write(ADR_CTRL, 16'hC000);
        bus_write(ADR_TXB, 16'h00AA);
        repeat (10) @(negedge clk);
        bus_read(ADR_CTRL, d); check("R11 busy before abort", d[BUSY_BIT], 1'b1);
        bus_write(ADR_CTRL, 16'h0000);
        bus_read(ADR_CTRL, d); check("R11 idle after abort", d[BUSY_BIT], 1'b0);
        check("R11 clock low after abort", ser_clk_o, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule